// File: doc/BRIEF.md
# Converter Serial Link Frame Assembler

This block sits between a 16-bit data converter core and a 20x bit serializer. Once per sample clock it takes one sample and builds a 20-bit frame word made of two 10-bit 8B/10B code groups. The sample is split into a high octet and a low octet. The high octet is sent first. The running disparity carries from one code group to the next and from one frame to the next.

A receiver-driven synchronization request replaces data with idle ordered sets. Each idle set is a K28.5 comma followed by a data character. That character is chosen so that the set always ends with negative disparity. Data octets can optionally pass through a self-synchronizing scrambler before encoding. A frame alignment monitor can replace an all-ones final octet with a K28.7 control character. A two-bit select can substitute built-in test patterns for the converter sample. The output is registered, with a fixed pipeline of two clock edges.

Top module: `frm_link_assembler`

## Requirements
- R1: While `rst_n` is low, `word_out` is all zeros. The running disparity starts negative, so the first idle after reset begins with the negative-disparity K28.5 form `0011111010`.
- R2: A sample captured at clock edge k appears on `word_out` after edge k+1. Sample bits 15:8 form the first code group in `word_out[19:10]`. Bits 7:0 form the second code group in `word_out[9:0]`.
- R3: Each code group follows the standard 8B/10B code, written as bits abcdei fghj with bit a in the group's MSB. A group starting from negative disparity carries five or six ones. A group starting from positive disparity carries four or five ones.
- R4: The running disparity is updated after every code group, data or control. It becomes positive after a group with six ones, negative after one with four ones, and is unchanged otherwise. The second group of a frame is encoded with the disparity left by the first.
- R5: While `sync_req` is high, each frame is an idle set: K28.5 first, then D16.2 (octet 0x50) if the disparity after the comma is positive, or D5.6 (octet 0xC5) if it is negative. The disparity is negative after every idle frame.
- R6: A sample captured with `sync_req` low is sent as data in that same frame, with no extra idle frame after the request drops.
- R7: When `scramble_en` is high in a data frame, the 16 bits are scrambled MSB first as y = d xor s14 xor s15. The 15-bit state holds the most recent scrambled bits and starts at 0x7FFF after reset. The state is held during idle frames and during data frames with scrambling off.
- R8: When `scramble_en` is low, the data octets reach the encoder unchanged.
- R9: When `align_mon_en` is high in a data frame and the second octet after scrambling is 0xFF, the second group is K28.7. Its negative-disparity form is `0011111000`; its positive-disparity form is the complement.
- R10: When `align_mon_en` is low, a second octet of 0xFF is sent as the data character D31.7, and no K28.7 appears.
- R11: `pattern_sel` selects the frame source before the scrambler: 0 = `sample_in`, 1 = alternating 0x5555/0xAAAA (0x5555 when the count is even), 2 = a ramp equal to the count, 3 = all zeros.
- R12: The pattern count is zero after reset. It rises by one after every data frame, whatever pattern is selected, and holds during idle frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one frame per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_in | input | 16 | Converter sample |
| sync_req | input | 1 | Receiver synchronization request; high sends idle sets |
| scramble_en | input | 1 | Enables the data scrambler |
| align_mon_en | input | 1 | Enables K28.7 substitution of an all-ones final octet |
| pattern_sel | input | 2 | Frame source select (see R11) |
| word_out | output | 20 | Two encoded code groups, first group in bits 19:10 |

## Verification
The bench pushes every octet value through both code-group positions, starting from either disparity. An encoder with one wrong table entry, or one that picks the wrong alternate 3b/4b form, would produce a group that differs from the computed one. Idle frames are entered from both positive and negative disparity; a design that fixed the trailing idle character instead of deriving it from the comma would end an idle positive. Scrambling is toggled and interleaved with idle frames, so a scrambler whose state drifts while it should hold gives wrong words on every later frame. The alignment monitor and test-pattern sweeps check K28.7 substitution and show that the pattern count moves only on data frames.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int OCT_W  = 8;
  localparam int CODE_W = 10;

  // negative-disparity forms of the two control characters used
  localparam logic [CODE_W-1:0] K285_NEG = 10'b0011111010;
  localparam logic [CODE_W-1:0] K287_NEG = 10'b0011111000;

  // octet values (K flag set for the control ones)
  localparam logic [OCT_W-1:0] OCT_K285  = 8'hBC;
  localparam logic [OCT_W-1:0] OCT_K287  = 8'hFC;
  localparam logic [OCT_W-1:0] OCT_D16_2 = 8'h50;
  localparam logic [OCT_W-1:0] OCT_D5_6  = 8'hC5;

  typedef enum logic [1:0] {
    SRC_SAMPLE = 2'd0,
    SRC_ALT    = 2'd1,
    SRC_RAMP   = 2'd2,
    SRC_ZERO   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/frm_pattern_src.sv
module frm_pattern_src #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [1:0]   sel,
  input  logic         adv,
  output logic [W-1:0] dout
);
  import frm_pkg::*;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_SAMPLE: dout = sample;
      SRC_ALT:    dout = cnt_q[0] ? {(W/2){2'b10}} : {(W/2){2'b01}};
      SRC_RAMP:   dout = cnt_q;
      default:    dout = '0;
    endcase
  end

  // R12: count moves by exactly one per data frame and holds otherwise
  assert_cnt_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt_q == W'($past(cnt_q) + 1'b1));
  assert_cnt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/frm_scrambler.sv
module frm_scrambler #(
  parameter int          W    = 16,
  parameter logic [14:0] SEED = 15'h7FFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [14:0] state_q, state_d;

  // 1 + x^14 + x^15, self-synchronizing, MSB first; state[0] is newest bit
  always_comb begin
    logic [14:0] st;
    logic        b;
    st = state_q;
    for (int i = W - 1; i >= 0; i--) begin
      b       = din[i] ^ st[13] ^ st[14];
      dout[i] = b;
      st      = {st[13:0], b};
    end
    state_d = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= state_d;
  end

  // R7: after an advancing frame the state equals the newest scrambled bits
  assert_state_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state_q == $past(dout[14:0]));
  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/frm_enc8b10b.sv
module frm_enc8b10b (
  input  logic [7:0] din,
  input  logic       is_k,
  input  logic       rd_in,   // 1 = positive running disparity
  output logic [9:0] code,
  output logic       rd_out
);
  logic [5:0] six_n, six;
  logic [3:0] four_n, four, kfour;
  logic       rd6, use_a7;
  logic [9:0] kbase;

  always_comb begin
    unique case (din[4:0])
      5'd0:  six_n = 6'b100111;  5'd1:  six_n = 6'b011101;
      5'd2:  six_n = 6'b101101;  5'd3:  six_n = 6'b110001;
      5'd4:  six_n = 6'b110101;  5'd5:  six_n = 6'b101001;
      5'd6:  six_n = 6'b011001;  5'd7:  six_n = 6'b111000;
      5'd8:  six_n = 6'b111001;  5'd9:  six_n = 6'b100101;
      5'd10: six_n = 6'b010101;  5'd11: six_n = 6'b110100;
      5'd12: six_n = 6'b001101;  5'd13: six_n = 6'b101100;
      5'd14: six_n = 6'b011100;  5'd15: six_n = 6'b010111;
      5'd16: six_n = 6'b011011;  5'd17: six_n = 6'b100011;
      5'd18: six_n = 6'b010011;  5'd19: six_n = 6'b110010;
      5'd20: six_n = 6'b001011;  5'd21: six_n = 6'b101010;
      5'd22: six_n = 6'b011010;  5'd23: six_n = 6'b111010;
      5'd24: six_n = 6'b110011;  5'd25: six_n = 6'b100110;
      5'd26: six_n = 6'b010110;  5'd27: six_n = 6'b110110;
      5'd28: six_n = 6'b001110;  5'd29: six_n = 6'b101110;
      5'd30: six_n = 6'b011110;  default: six_n = 6'b101011;
    endcase
    if (rd_in && (($countones(six_n) != 3) || (six_n == 6'b111000)))
      six = ~six_n;
    else
      six = six_n;
    rd6    = ($countones(six) == 3) ? rd_in : ($countones(six) > 3);
    use_a7 = (din[7:5] == 3'd7) &&
             ((!rd6 && six[1:0] == 2'b11) || (rd6 && six[1:0] == 2'b00));
    unique case (din[7:5])
      3'd0: four_n = 4'b1011;  3'd1: four_n = 4'b1001;
      3'd2: four_n = 4'b0101;  3'd3: four_n = 4'b1100;
      3'd4: four_n = 4'b1101;  3'd5: four_n = 4'b1010;
      3'd6: four_n = 4'b0110;  default: four_n = use_a7 ? 4'b0111 : 4'b1110;
    endcase
    if (rd6 && (($countones(four_n) != 2) || (four_n == 4'b1100)))
      four = ~four_n;
    else
      four = four_n;
    // K28.y, negative-disparity form; positive form is the full complement
    unique case (din[7:5])
      3'd0: kfour = 4'b0100;  3'd1: kfour = 4'b1001;
      3'd2: kfour = 4'b0101;  3'd3: kfour = 4'b0011;
      3'd4: kfour = 4'b0010;  3'd5: kfour = 4'b1010;
      3'd6: kfour = 4'b0110;  default: kfour = 4'b1000;
    endcase
    kbase = {6'b001111, kfour};
    if (is_k) code = rd_in ? ~kbase : kbase;
    else      code = {six, four};
    rd_out = ($countones(code) == 5) ? rd_in : ($countones(code) > 5);
  end

  // R3: group disparity bounded by the disparity it started from
  always_comb begin
    assert_disp_bounded_R3: assert (rd_in ? ($countones(code) inside {4, 5})
                                          : ($countones(code) inside {5, 6}))
      else $error("code group disparity out of range");
  end
endmodule

// File: rtl/frm_link_assembler.sv
module frm_link_assembler #(
  parameter int          SAMPLE_W = 16,
  parameter logic [14:0] SCR_SEED = 15'h7FFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SAMPLE_W-1:0]        sample_in,
  input  logic                       sync_req,
  input  logic                       scramble_en,
  input  logic                       align_mon_en,
  input  logic [1:0]                 pattern_sel,
  output logic [SAMPLE_W/8*10-1:0]   word_out
);
  import frm_pkg::*;

  localparam int GROUPS = SAMPLE_W / OCT_W;
  localparam int WORD_W = GROUPS * CODE_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // stage 1: frame source and per-frame controls
  logic [SAMPLE_W-1:0] pat_data;
  logic                pat_adv;
  logic [SAMPLE_W-1:0] s1_data_q, s1_data_d;
  logic                s1_idle_q, s1_idle_d;
  logic                s1_scr_q,  s1_scr_d;
  logic                s1_fam_q,  s1_fam_d;

  assign pat_adv = !sync_req;

  frm_pattern_src #(.W(SAMPLE_W)) u_pat (
    .clk    (clk),
    .rst_n  (rst_q),
    .sample (sample_in),
    .sel    (pattern_sel),
    .adv    (pat_adv),
    .dout   (pat_data)
  );

  always_comb begin
    s1_data_d = pat_data;
    s1_idle_d = sync_req;
    s1_scr_d  = scramble_en;
    s1_fam_d  = align_mon_en;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_data_q <= '0;
      s1_idle_q <= 1'b1;
      s1_scr_q  <= 1'b0;
      s1_fam_q  <= 1'b0;
    end else begin
      s1_data_q <= s1_data_d;
      s1_idle_q <= s1_idle_d;
      s1_scr_q  <= s1_scr_d;
      s1_fam_q  <= s1_fam_d;
    end
  end

  // stage 2: scramble, encode, register
  logic                scr_adv;
  logic [SAMPLE_W-1:0] scr_out, enc_in;
  logic [GROUPS:0]     rd_chain;
  logic [WORD_W-1:0]   word_d;
  logic                rd_q;

  assign scr_adv = !s1_idle_q && s1_scr_q;

  frm_scrambler #(.W(SAMPLE_W), .SEED(SCR_SEED)) u_scr (
    .clk   (clk),
    .rst_n (rst_q),
    .adv   (scr_adv),
    .din   (s1_data_q),
    .dout  (scr_out)
  );

  assign enc_in      = s1_scr_q ? scr_out : s1_data_q;
  assign rd_chain[0] = rd_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [OCT_W-1:0] oct, sel_oct;
    logic             sel_k;
    assign oct = enc_in[SAMPLE_W-1-OCT_W*g -: OCT_W];
    always_comb begin
      sel_oct = oct;
      sel_k   = 1'b0;
      if (s1_idle_q) begin
        if (g == 0) begin
          sel_oct = OCT_K285;
          sel_k   = 1'b1;
        end else begin
          sel_oct = rd_chain[g] ? OCT_D16_2 : OCT_D5_6;
        end
      end else if ((g == GROUPS - 1) && s1_fam_q && (oct == 8'hFF)) begin
        sel_oct = OCT_K287;
        sel_k   = 1'b1;
      end
    end
    frm_enc8b10b u_enc (
      .din    (sel_oct),
      .is_k   (sel_k),
      .rd_in  (rd_chain[g]),
      .code   (word_d[WORD_W-1-CODE_W*g -: CODE_W]),
      .rd_out (rd_chain[g+1])
    );
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      word_out <= '0;
      rd_q     <= 1'b0;
    end else begin
      word_out <= word_d;
      rd_q     <= rd_chain[GROUPS];
    end
  end

  // R5: idle frames open with a comma and close at negative disparity
  assert_idle_comma_R5: assert property (@(posedge clk) disable iff (!rst_q)
    s1_idle_q |=> (word_out[WORD_W-1 -: CODE_W] == K285_NEG) ||
                  (word_out[WORD_W-1 -: CODE_W] == ~K285_NEG));
  assert_idle_ends_neg_R5: assert property (@(posedge clk) disable iff (!rst_q)
    s1_idle_q |=> !rd_q);
  // R10: without the monitor no K28.7 reaches the last group
  assert_no_sub_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (!s1_fam_q || s1_idle_q) |=> (word_out[CODE_W-1:0] != K287_NEG) &&
                                 (word_out[CODE_W-1:0] != ~K287_NEG));
endmodule

// File: tb/frm_link_assembler_test.sv
`timescale 1ns/1ps
module frm_link_assembler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] sample_in = '0;
  logic        sync_req = 1'b1;
  logic        scramble_en = 1'b0;
  logic        align_mon_en = 1'b0;
  logic [1:0]  pattern_sel = 2'd0;
  logic [19:0] word_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  frm_link_assembler uut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sync_req(sync_req),
    .scramble_en(scramble_en), .align_mon_en(align_mon_en),
    .pattern_sel(pattern_sel), .word_out(word_out)
  );

  // standard 5b/6b and 3b/4b codes, negative-disparity column
  localparam logic [5:0] T6 [32] = '{
    6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
    6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
    6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
    6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
    6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
    6'b011110, 6'b101011};
  localparam logic [3:0] T4 [8] = '{
    4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};

  // reference model state
  logic        m_rd  = 1'b0;
  logic [14:0] m_scr = 15'h7FFF;
  logic [15:0] m_cnt = '0;

  logic        pv [2]   = '{1'b0, 1'b0};
  logic [19:0] pexp [2];
  string       ptag [2];

  task automatic upd_rd(input logic [9:0] c);
    if ($countones(c) == 6) m_rd = 1'b1;
    else if ($countones(c) == 4) m_rd = 1'b0;
  endtask

  task automatic enc_d(input logic [7:0] b, output logic [9:0] c);
    logic [5:0] s; logic [3:0] f; logic r6; logic a7;
    s = T6[b[4:0]];
    if (m_rd && ($countones(s) != 3 || s == 6'b111000)) s = ~s;
    r6 = ($countones(s) == 3) ? m_rd : ($countones(s) > 3);
    a7 = (b[7:5] == 3'd7) && ((!r6 && s[1:0] == 2'b11) || (r6 && s[1:0] == 2'b00));
    f = a7 ? 4'b0111 : T4[b[7:5]];
    if (r6 && ($countones(f) != 2 || f == 4'b1100)) f = ~f;
    c = {s, f};
    upd_rd(c);
  endtask

  task automatic enc_k(input logic [9:0] neg_form, output logic [9:0] c);
    c = m_rd ? ~neg_form : neg_form;
    upd_rd(c);
  endtask

  task automatic model(input logic [15:0] smp, input logic sync, input logic scr,
                       input logic fam, input logic [1:0] pat, output logic [19:0] w);
    logic [9:0] g0, g1; logic [15:0] v; logic bt;
    if (sync) begin
      enc_k(10'b0011111010, g0);
      enc_d(m_rd ? 8'h50 : 8'hC5, g1);
    end else begin
      case (pat)
        2'd0: v = smp;
        2'd1: v = m_cnt[0] ? 16'hAAAA : 16'h5555;
        2'd2: v = m_cnt;
        default: v = 16'h0000;
      endcase
      m_cnt = m_cnt + 16'd1;
      if (scr) begin
        for (int i = 15; i >= 0; i--) begin
          bt = v[i] ^ m_scr[13] ^ m_scr[14];
          v[i] = bt;
          m_scr = {m_scr[13:0], bt};
        end
      end
      enc_d(v[15:8], g0);
      if (fam && v[7:0] == 8'hFF) enc_k(10'b0011111000, g1);
      else enc_d(v[7:0], g1);
    end
    w = {g0, g1};
  endtask

  task automatic check(input logic [19:0] act, input logic [19:0] exp, input string rq);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: word_out=%h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] smp, input logic sync, input logic scr,
                      input logic fam, input logic [1:0] pat, input string rq);
    logic [19:0] e;
    @(negedge clk);
    if (pv[1]) check(word_out, pexp[1], ptag[1]);
    pv[1] = pv[0]; pexp[1] = pexp[0]; ptag[1] = ptag[0];
    sample_in = smp; sync_req = sync; scramble_en = scr;
    align_mon_en = fam; pattern_sel = pat;
    model(smp, sync, scr, fam, pat, e);
    pv[0] = 1'b1; pexp[0] = e; ptag[0] = rq;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(word_out, 20'h0, "R1 reset");
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 R5: first idles after reset start from negative disparity
    check(word_out, {10'b0011111010, 10'b1001000101}, "R1 R5 first idle");

    // R2 R3 R4: every octet value in both positions
    for (int i = 0; i < 256; i++)
      step({i[7:0], ~i[7:0]}, 1'b0, 1'b0, 1'b0, 2'd0, "R2 R3 R4 octet sweep");

    // R5 R6: idles entered from either disparity, data resumes at once
    for (int i = 0; i < 96; i++)
      step(16'(i * 1031 + 7), (i % 3 == 0), 1'b0, 1'b0, 2'd0, "R5 R6 idle/data mix");

    // R7 R8: scrambling on and off, with idles holding the state
    for (int i = 0; i < 256; i++)
      step({i[7:0], i[7:0] ^ 8'h5A}, (i % 7 == 3), (i % 5 != 0), 1'b0, 2'd0,
           "R7 R8 scramble");

    // R9: monitor replaces all-ones final octet, from both disparities
    for (int i = 0; i < 32; i++)
      step({i[4:0], 3'b101, 8'hFF}, 1'b0, 1'b0, 1'b1, 2'd0, "R9 K28.7 substitution");
    // R10: monitor off leaves all-ones octet as data
    for (int i = 0; i < 16; i++)
      step({i[3:0], 4'hC, 8'hFF}, 1'b0, 1'b0, 1'b0, 2'd0, "R10 no substitution");
    // R9 with scrambling active
    for (int i = 0; i < 64; i++)
      step(16'(i * 40503), 1'b0, 1'b1, 1'b1, 2'd0, "R9 R7 monitor after scramble");

    // R11 R12: patterns, with idles to show the count holds
    for (int i = 0; i < 48; i++)
      step(16'(i * 7919), (i % 4 == 1), (i >= 40), 1'b0, 2'(i / 12),
           "R11 R12 patterns");

    step(16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R5 flush");
    step(16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R5 flush");
    step(16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R5 flush");
    finish_run();
  end
endmodule